// File: doc/BRIEF.md
# Priority Overtaking Output Arbiter

This block is the output arbitration and header buffering stage of a five-port packet switch. Port 0 faces the local node and ports 1 to 4 face neighbouring switches; the arbiter treats all five alike. Each cycle any input may present a header with an 8-bit priority, a 5-bit output mask and a short tag. Every output independently picks the strongest live header that wants it, so an urgent packet overtakes older, weaker traffic at each hop. Headers that lose, and the unserved outputs of multicast headers, stay in an eight-entry overtaking buffer. The buffer is kept sorted by rank.

When more headers survive a cycle than the buffer can hold, the weakest ones leave in the same cycle through spill lanes toward a backing store. This includes fresh arrivals that rank below everything already held. When the buffer has room and no eviction is pending, a refill port takes headers back from the store. The store hands back its best header first, so priority order holds across the spill and refill round trip.

Ranking is strict. Higher priority wins. At equal priority, the earlier arrival wins. Headers that arrived in the same cycle are ordered by lower input port. Arrival time rides in each header as a stamp, so a header that comes back from the store keeps its seniority.

Top module: `ova_arbiter`

## Requirements
- R1: A header that has no competitor for an output appears on that output's forward lane on the first clock edge after it is presented.
- R2: In every cycle, each output forwards the live header with the largest priority value (0 to 255) that requests it, independently of the other outputs.
- R3: At equal priority, the header that arrived in an earlier cycle wins, including a buffered header against a new arrival. Among same-cycle arrivals, the lower input port wins.
- R4: A header that loses keeps its unserved mask bits in the buffer and is forwarded later. A multicast header is forwarded exactly once on each output in its mask and is then retired.
- R5: When more than DEPTH headers survive a cycle, the excess with the lowest ranks leaves that same cycle on spill lanes. Lane 0 carries the best of the excess, and the following lanes carry the rest in descending rank. An arrival ranked below the whole buffer is spilled directly. The spill word is laid out as tag [32:29], priority [28:21], mask [20:16] and arrival stamp [15:0]. An idle lane carries all zeros.
- R6: refill_ready is high only when fewer than DEPTH headers survive the cycle. No eviction occurs in a cycle that accepts a refill. An accepted header joins the buffer and can be forwarded from the next cycle on.
- R7: When the store returns its highest-priority header first, an output forwards a congested stream in descending priority order, spilled headers included.
- R8: While spill_ready is low, arr_ready is low, arrivals are discarded and nothing is spilled.
- R9: After reset all forward and spill lanes are idle, the buffer is empty and refill_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 5 | Header present on each input port |
| arr_prio | input | 5x8 | Priority per input port |
| arr_mask | input | 5x5 | Requested outputs per input port |
| arr_tag | input | 5x4 | Packet tag per input port |
| arr_ready | output | 1 | Arrivals are accepted this cycle |
| fwd_valid | output | 5 | Header forwarded on each output |
| fwd_prio | output | 5x8 | Priority of the forwarded header |
| fwd_tag | output | 5x4 | Tag of the forwarded header |
| spill_valid | output | 5 | Spill lane carries an evicted header |
| spill_data | output | 5x33 | Evicted header words |
| spill_ready | input | 1 | Backing store can take spills this cycle |
| refill_valid | input | 1 | Store offers a header back |
| refill_data | input | 33 | Offered header word |
| refill_ready | output | 1 | Buffer takes the offered header |

## Verification
Forwarding and eviction can happen in the same cycle. Five headers aimed at one output arrive while the buffer is already full. The strongest one must go out on the forward lane. In that same cycle the two weakest arrivals and the two weakest buffered headers must leave on spill lanes 0 to 3, in descending priority. The check compares the lane contents in that cycle, confirms that refill_ready stays low, and then requires the whole stream to drain on the output in descending priority while the bench store feeds the spilled headers back.

// File: rtl/ova_pkg.sv
package ova_pkg;

    localparam int NPORT     = 5;
    localparam int BUF_DEPTH = 8;
    localparam int PRIO_W    = 8;
    localparam int TAG_W     = 4;
    localparam int STAMP_W   = 16;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [PRIO_W-1:0]  prio;
        logic [NPORT-1:0]   mask;
        logic [STAMP_W-1:0] stamp;
    } hdr_t;

    localparam int HDR_W = $bits(hdr_t);

    // Strict order: priority, then age (modular), then candidate index.
    function automatic logic outranks(
        input logic [PRIO_W-1:0]  pa,
        input logic [STAMP_W-1:0] sa,
        input logic [PRIO_W-1:0]  pb,
        input logic [STAMP_W-1:0] sb,
        input logic [STAMP_W-1:0] now,
        input int                 ia,
        input int                 ib
    );
        logic [STAMP_W-1:0] age_a;
        logic [STAMP_W-1:0] age_b;
        age_a = now - sa;
        age_b = now - sb;
        if (pa != pb)       return pa > pb;
        if (age_a != age_b) return age_a > age_b;
        return ia < ib;
    endfunction

endpackage

// File: rtl/ova_rank_matrix.sv
module ova_rank_matrix
    import ova_pkg::*;
#(
    parameter int NC = 4
) (
    input  logic [PRIO_W-1:0]  prio  [NC],
    input  logic [STAMP_W-1:0] stamp [NC],
    input  logic [STAMP_W-1:0] now,
    output logic [NC-1:0]      beats [NC]
);

    generate
        for (genvar i = 0; i < NC; i++) begin : g_row
            always_comb begin
                for (int j = 0; j < NC; j++) begin
                    beats[i][j] = (i != j) &&
                                  outranks(prio[i], stamp[i], prio[j], stamp[j], now, i, j);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ova_port_select.sv
module ova_port_select
    import ova_pkg::*;
#(
    parameter int NC = 4
) (
    input  logic [NC-1:0]    req,
    input  logic [NPORT-1:0] mask  [NC],
    input  logic [NC-1:0]    beats [NC],
    output logic [NC-1:0]    win   [NPORT],
    output logic [NPORT-1:0] left  [NC]
);

    generate
        for (genvar o = 0; o < NPORT; o++) begin : g_out
            always_comb begin
                for (int i = 0; i < NC; i++) begin
                    win[o][i] = req[i] && mask[i][o];
                    for (int j = 0; j < NC; j++) begin
                        if ((j != i) && req[j] && mask[j][o] && !beats[i][j])
                            win[o][i] = 1'b0;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                left[i][o] = mask[i][o] && !win[o][i];
            end
        end
    end

endmodule

// File: rtl/ova_placer.sv
module ova_placer
    import ova_pkg::*;
#(
    parameter int NC    = 4,
    parameter int DEPTH = 2
) (
    input  logic [NC-1:0]    alive,
    input  hdr_t             cand   [NC],
    input  logic [NC-1:0]    beats  [NC],
    output logic [DEPTH-1:0] slot_v,
    output hdr_t             slot_h [DEPTH],
    output logic [NPORT-1:0] lane_v,
    output hdr_t             lane_h [NPORT]
);

    localparam int RW = $clog2(NC + 1);

    logic [RW-1:0] rank [NC];

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            rank[i] = '0;
            for (int j = 0; j < NC; j++) begin
                if (alive[j] && beats[j][i]) rank[i] = rank[i] + 1'b1;
            end
        end
    end

    always_comb begin
        slot_v = '0;
        lane_v = '0;
        for (int k = 0; k < DEPTH; k++) slot_h[k] = '0;
        for (int l = 0; l < NPORT; l++) lane_h[l] = '0;
        for (int i = 0; i < NC; i++) begin
            int r;
            r = int'(rank[i]);
            if (alive[i]) begin
                if (r < DEPTH) begin
                    slot_v[r] = 1'b1;
                    slot_h[r] = cand[i];
                end else if (r < DEPTH + NPORT) begin
                    lane_v[r - DEPTH] = 1'b1;
                    lane_h[r - DEPTH] = cand[i];
                end
            end
        end
    end

endmodule

// File: rtl/ova_arbiter.sv
module ova_arbiter
    import ova_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0]              arr_valid,
    input  logic [NPORT-1:0][PRIO_W-1:0]  arr_prio,
    input  logic [NPORT-1:0][NPORT-1:0]   arr_mask,
    input  logic [NPORT-1:0][TAG_W-1:0]   arr_tag,
    output logic                          arr_ready,
    output logic [NPORT-1:0]              fwd_valid,
    output logic [NPORT-1:0][PRIO_W-1:0]  fwd_prio,
    output logic [NPORT-1:0][TAG_W-1:0]   fwd_tag,
    output logic [NPORT-1:0]              spill_valid,
    output logic [NPORT-1:0][HDR_W-1:0]   spill_data,
    input  logic                          spill_ready,
    input  logic                          refill_valid,
    input  logic [HDR_W-1:0]              refill_data,
    output logic                          refill_ready
);

    localparam int NC  = DEPTH + NPORT + 1;
    localparam int RFI = NC - 1;

    logic [STAMP_W-1:0] now_q;
    logic [DEPTH-1:0]   buf_v;
    hdr_t               buf_h [DEPTH];

    hdr_t               cand      [NC];
    hdr_t               cand_post [NC];
    logic [NC-1:0]      req;
    logic [NC-1:0]      alive;
    logic [PRIO_W-1:0]  c_prio  [NC];
    logic [STAMP_W-1:0] c_stamp [NC];
    logic [NPORT-1:0]   c_mask  [NC];
    logic [NC-1:0]      beats   [NC];
    logic [NC-1:0]      win     [NPORT];
    logic [NPORT-1:0]   left    [NC];
    logic [DEPTH-1:0]   slot_v;
    hdr_t               slot_h  [DEPTH];
    logic [NPORT-1:0]   lane_v;
    hdr_t               lane_h  [NPORT];

    logic [NPORT-1:0]             fv_d;
    logic [NPORT-1:0][PRIO_W-1:0] fp_d;
    logic [NPORT-1:0][TAG_W-1:0]  ft_d;

    assign arr_ready = spill_ready;

    // Candidate vector: buffer slots, then input ports, then the refill offer.
    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            cand[k] = buf_h[k];
            req[k]  = buf_v[k];
        end
        for (int p = 0; p < NPORT; p++) begin
            cand[DEPTH+p].tag   = arr_tag[p];
            cand[DEPTH+p].prio  = arr_prio[p];
            cand[DEPTH+p].mask  = arr_mask[p];
            cand[DEPTH+p].stamp = now_q;
            req[DEPTH+p]        = arr_valid[p] && spill_ready && (arr_mask[p] != '0);
        end
        cand[RFI] = hdr_t'(refill_data);
        req[RFI]  = 1'b0;
        for (int i = 0; i < NC; i++) begin
            c_prio[i]  = cand[i].prio;
            c_stamp[i] = cand[i].stamp;
            c_mask[i]  = cand[i].mask;
        end
    end

    ova_rank_matrix #(.NC(NC)) u_rank (
        .prio  (c_prio),
        .stamp (c_stamp),
        .now   (now_q),
        .beats (beats)
    );

    ova_port_select #(.NC(NC)) u_sel (
        .req   (req),
        .mask  (c_mask),
        .beats (beats),
        .win   (win),
        .left  (left)
    );

    // Survivors after service decide whether the refill offer fits.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < RFI; i++) begin
            alive[i] = req[i] && (left[i] != '0);
            if (alive[i]) cnt = cnt + 1;
        end
        refill_ready = (cnt < DEPTH);
        alive[RFI]   = refill_valid && refill_ready;
        for (int i = 0; i < NC; i++) begin
            cand_post[i]      = cand[i];
            cand_post[i].mask = left[i];
        end
    end

    ova_placer #(.NC(NC), .DEPTH(DEPTH)) u_place (
        .alive  (alive),
        .cand   (cand_post),
        .beats  (beats),
        .slot_v (slot_v),
        .slot_h (slot_h),
        .lane_v (lane_v),
        .lane_h (lane_h)
    );

    always_comb begin
        for (int l = 0; l < NPORT; l++) spill_data[l] = lane_h[l];
    end
    assign spill_valid = lane_v;

    always_comb begin
        fv_d = '0;
        fp_d = '0;
        ft_d = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NC; i++) begin
                if (win[o][i]) begin
                    fv_d[o] = 1'b1;
                    fp_d[o] = cand[i].prio;
                    ft_d[o] = cand[i].tag;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q     <= '0;
            buf_v     <= '0;
            fwd_valid <= '0;
            fwd_prio  <= '0;
            fwd_tag   <= '0;
            for (int k = 0; k < DEPTH; k++) buf_h[k] <= '0;
        end else begin
            now_q     <= now_q + 1'b1;
            buf_v     <= slot_v;
            fwd_valid <= fv_d;
            fwd_prio  <= fp_d;
            fwd_tag   <= ft_d;
            for (int k = 0; k < DEPTH; k++) buf_h[k] <= slot_h[k];
        end
    end

endmodule

// File: rtl/ova_arbiter_chk.sv
module ova_arbiter_chk
    import ova_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [NPORT-1:0]            fwd_valid,
    input logic [NPORT-1:0]            spill_valid,
    input logic [NPORT-1:0][HDR_W-1:0] spill_data,
    input logic                        spill_ready,
    input logic                        refill_valid,
    input logic                        refill_ready
);

    localparam int PRIO_LSB = NPORT + STAMP_W;

    // R8
    no_spill_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        !spill_ready |-> spill_valid == '0);

    // R6
    refill_no_evict_chk: assert property (@(posedge clk) disable iff (rst)
        (refill_valid && refill_ready) |-> spill_valid == '0);

    // R9
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (fwd_valid == '0 && spill_valid == '0));

    generate
        for (genvar l = 0; l < NPORT; l++) begin : g_lane
            // R5
            idle_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
                !spill_valid[l] |-> spill_data[l] == '0);
            if (l > 0) begin : g_ord
                // R5
                lane_order_chk: assert property (@(posedge clk) disable iff (rst)
                    spill_valid[l] |-> (spill_valid[l-1] &&
                        spill_data[l-1][PRIO_LSB +: PRIO_W] >= spill_data[l][PRIO_LSB +: PRIO_W]));
            end
        end
    endgenerate

endmodule

bind ova_arbiter ova_arbiter_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .fwd_valid    (fwd_valid),
    .spill_valid  (spill_valid),
    .spill_data   (spill_data),
    .spill_ready  (spill_ready),
    .refill_valid (refill_valid),
    .refill_ready (refill_ready)
);

// File: tb/test_ova_arbiter.sv
module test_ova_arbiter;
    import ova_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [NPORT-1:0]            arr_valid = '0;
    logic [NPORT-1:0][PRIO_W-1:0] arr_prio = '0;
    logic [NPORT-1:0][NPORT-1:0] arr_mask = '0;
    logic [NPORT-1:0][TAG_W-1:0] arr_tag = '0;
    logic                        arr_ready;
    logic [NPORT-1:0]            fwd_valid;
    logic [NPORT-1:0][PRIO_W-1:0] fwd_prio;
    logic [NPORT-1:0][TAG_W-1:0] fwd_tag;
    logic [NPORT-1:0]            spill_valid;
    logic [NPORT-1:0][HDR_W-1:0] spill_data;
    logic                        spill_ready = 1'b1;
    logic                        refill_valid = 1'b0;
    logic [HDR_W-1:0]            refill_data = '0;
    logic                        refill_ready;

    ova_arbiter i_ova_arbiter (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int tk = 0;

    // Backing store model and output logs.
    logic [HDR_W-1:0] st [64];
    int               st_n = 0;
    int               log_n [NPORT];
    logic [7:0]       log_p [NPORT][32];
    logic [3:0]       log_t [NPORT][32];
    int               log_k [NPORT][32];

    logic [NPORT-1:0]            s_spill_v;
    logic [NPORT-1:0][HDR_W-1:0] s_spill_d;
    logic                        s_refill_rdy;
    logic                        s_arr_rdy;

    typedef struct packed {
        logic [4:0]        v;
        logic [4:0][7:0]   prio;
        logic [4:0][4:0]   mask;
        logic [4:0][11:0]  exp;
    } row_t;

    localparam int NROWS = 6;
    localparam row_t ROWS [NROWS] = '{
        '{v:5'b00010, prio:{8'd0,8'd0,8'd0,8'd10,8'd0},
          mask:{5'b0,5'b0,5'b0,5'b00100,5'b0},
          exp:{12'h0,12'h0,12'h200,12'h0,12'h0}},
        '{v:5'b01001, prio:{8'd0,8'd9,8'd0,8'd0,8'd5},
          mask:{5'b0,5'b00010,5'b0,5'b0,5'b00010},
          exp:{12'h0,12'h0,12'h0,12'h410,12'h0}},
        '{v:5'b00011, prio:{8'd0,8'd0,8'd0,8'd200,8'd1},
          mask:{5'b0,5'b0,5'b0,5'b10000,5'b01000},
          exp:{12'h200,12'h100,12'h0,12'h0,12'h0}},
        '{v:5'b10100, prio:{8'd7,8'd0,8'd7,8'd0,8'd0},
          mask:{5'b10000,5'b0,5'b10001,5'b0,5'b0},
          exp:{12'h350,12'h0,12'h0,12'h0,12'h300}},
        '{v:5'b01110, prio:{8'd0,8'd3,8'd250,8'd3,8'd0},
          mask:{5'b0,5'b00001,5'b00001,5'b00001,5'b0},
          exp:{12'h0,12'h0,12'h0,12'h0,12'h324}},
        '{v:5'b10001, prio:{8'd120,8'd0,8'd0,8'd0,8'd100},
          mask:{5'b00100,5'b0,5'b0,5'b0,5'b00111},
          exp:{12'h0,12'h0,12'h510,12'h100,12'h100}}
    };

    function automatic string row_req(input int r);
        case (r)
            0:       return "R1";
            1, 2:    return "R2";
            3, 4:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int o = 0; o < NPORT; o++) log_n[o] = 0;
    endtask

    task automatic clr_arr();
        arr_valid = '0;
        arr_prio  = '0;
        arr_mask  = '0;
        arr_tag   = '0;
    endtask

    task automatic set_arr(input int p, input int pr, input logic [4:0] m);
        arr_valid[p] = 1'b1;
        arr_prio[p]  = 8'(pr);
        arr_mask[p]  = m;
        arr_tag[p]   = 4'(p + 1);
    endtask

    // One cycle: inputs are already set just after a falling edge.
    task automatic tick();
        int best;
        tk++;
        best = 0;
        for (int k = 1; k < st_n; k++)
            if (st[k][28:21] > st[best][28:21]) best = k;
        refill_valid = (st_n > 0);
        refill_data  = (st_n > 0) ? st[best] : '0;
        #1;
        s_spill_v    = spill_valid;
        s_spill_d    = spill_data;
        s_refill_rdy = refill_ready;
        s_arr_rdy    = arr_ready;
        if (refill_valid && refill_ready) begin
            for (int k = best; k < st_n - 1; k++) st[k] = st[k+1];
            st_n--;
        end
        if (spill_ready) begin
            for (int l = 0; l < NPORT; l++)
                if (spill_valid[l] && st_n < 64) begin
                    st[st_n] = spill_data[l];
                    st_n++;
                end
        end
        for (int o = 0; o < NPORT; o++) begin
            if (fwd_valid[o] && log_n[o] < 32) begin
                log_p[o][log_n[o]] = fwd_prio[o];
                log_t[o][log_n[o]] = fwd_tag[o];
                log_k[o][log_n[o]] = tk;
                log_n[o]++;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t0;
        int exp_seq [15];
        exp_seq = '{24, 34, 42, 41, 40, 33, 32, 31, 30, 23, 22, 21, 20, 6, 5};
        clear_log();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        tick();
        chk("R9", "fwd_valid after reset", longint'(fwd_valid), 0);
        chk("R9", "spill_valid after reset", longint'(s_spill_v), 0);
        chk("R9", "refill_ready after reset", longint'(s_refill_rdy), 1);

        // Vector table: one arrival cycle, then drain.
        for (int r = 0; r < NROWS; r++) begin
            clear_log();
            t0 = tk + 1;
            for (int p = 0; p < NPORT; p++)
                if (ROWS[r].v[p]) set_arr(p, int'(ROWS[r].prio[p]), ROWS[r].mask[p]);
            tick();
            clr_arr();
            repeat (5) tick();
            for (int o = 0; o < NPORT; o++) begin
                logic [11:0] got;
                int          en;
                got = '0;
                en  = 0;
                for (int n = 0; n < 3; n++) begin
                    if (ROWS[r].exp[o][11-4*n -: 4] != 4'h0) en++;
                    if (n < log_n[o]) got[11-4*n -: 4] = log_t[o][n];
                end
                chk(row_req(r), $sformatf("row %0d out %0d tag order", r, o),
                    longint'({log_n[o], got}), longint'({en, ROWS[r].exp[o]}));
                if (en > 0 && log_n[o] > 0)
                    chk("R1", $sformatf("row %0d out %0d latency", r, o), log_k[o][0], t0 + 1);
            end
        end

        // R3: buffered header beats a newer arrival of equal priority
        clear_log();
        set_arr(1, 50, 5'b00001);
        set_arr(2, 60, 5'b00001);
        tick();
        clr_arr();
        set_arr(0, 50, 5'b00001);
        tick();
        clr_arr();
        repeat (4) tick();
        chk("R3", "age tie count", log_n[0], 3);
        chk("R3", "age tie first", longint'(log_t[0][0]), 3);
        chk("R3", "age tie older wins", longint'(log_t[0][1]), 2);
        chk("R3", "age tie newer last", longint'(log_t[0][2]), 1);

        // R5, R6, R7: fill, spill in the same cycle as forwarding, refill, drain
        clear_log();
        for (int p = 0; p < NPORT; p++) set_arr(p, 20 + p, 5'b00001);
        tick();
        clr_arr();
        for (int p = 0; p < NPORT; p++) set_arr(p, 30 + p, 5'b00001);
        tick();
        chk("R5", "exact fill spills nothing", longint'(s_spill_v), 0);
        clr_arr();
        set_arr(0, 5, 5'b00001);
        set_arr(1, 6, 5'b00001);
        set_arr(2, 40, 5'b00001);
        set_arr(3, 41, 5'b00001);
        set_arr(4, 42, 5'b00001);
        tick();
        clr_arr();
        chk("R5", "overflow lanes", longint'(s_spill_v), 15);
        chk("R5", "lane0 prio", longint'(s_spill_d[0][28:21]), 21);
        chk("R5", "lane1 prio", longint'(s_spill_d[1][28:21]), 20);
        chk("R5", "lane2 direct spill prio", longint'(s_spill_d[2][28:21]), 6);
        chk("R5", "lane3 direct spill prio", longint'(s_spill_d[3][28:21]), 5);
        chk("R6", "no refill while overflowing", longint'(s_refill_rdy), 0);
        repeat (20) tick();
        chk("R7", "drain length", log_n[0], 15);
        for (int n = 0; n < 15; n++)
            chk("R7", $sformatf("drain item %0d", n), longint'(log_p[0][n]), exp_seq[n]);
        chk("R6", "store emptied by refill", st_n, 0);

        // R8: blocked spill path discards arrivals
        clear_log();
        spill_ready = 1'b0;
        set_arr(0, 99, 5'b00100);
        tick();
        chk("R8", "arr_ready low", longint'(s_arr_rdy), 0);
        clr_arr();
        spill_ready = 1'b1;
        repeat (3) tick();
        chk("R8", "discarded arrival not forwarded", log_n[2], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule